// File: doc/BRIEF.md
# Frame-Buffer Host Write Port with Rotation

This block sits between a small host processor and the SRAM frame buffer that a display scan engine reads continuously. The host sees five registers: a control register, a status register, two address-field registers and a data register. A write to the data register latches one pixel together with the current frame-buffer address, and the address then advances by itself. The SRAM belongs to the scan engine. The latched pixel therefore waits until the scan engine raises its access window, which comes once per group of eight displayed pixels. The write is committed in that cycle.

Only one write can wait at a time. A host that writes again before the window has come loses that write, and a sticky overrun flag records the loss. A control bit changes which address field advances after each write. In normal mode the pixel field steps along a line. In rotated mode the line field steps down a column, which draws the image turned by 90 degrees.

Register select codes: 0 control, 1 status, 2 line field, 3 pixel field, 4 pixel data. Codes 5 to 7 read as zero. The frame-buffer address is `{line, pixel}`: the line field takes the upper bits and the pixel field the lower bits.

Top module: `fbwr_port`

## Requirements
- R1: After reset the control, status, line and pixel registers read 0 and `sram_we` is low.
- R2: A data-register write (select 4) while status bit 0 (busy) is clear latches the low `DATA_W` bits and the current `{line, pixel}` address. Busy reads 1 from the next cycle.
- R3: `sram_we` is high only in a cycle where `slot_open` is high and a write is pending. In that cycle `sram_addr` and `sram_wdata` carry the latched address and data.
- R4: Busy reads 0 in the cycle after the commit cycle.
- R5: A data-register write while busy is set is dropped, so the pending data stays as it was. Status bit 1 (overrun) becomes 1.
- R6: Writing status with bit 1 set clears overrun. Writing status with bit 1 clear leaves it unchanged.
- R7: With control bit 0 (rotate) clear, each accepted data write increments the pixel field. When the pixel field is at PIXELS-1 (319) it wraps to 0 and the line field increments, and the line field wraps from LINES-1 (239) to 0.
- R8: With rotate set, each accepted write increments the line field. When the line field is at 239 it wraps to 0 and the pixel field increments, and the pixel field wraps from 319 to 0.
- R9: Writes to select 2 and select 3 load the line and pixel fields directly, and reads of those selects return them.
- R10: `slot_open` with no write pending produces no SRAM write.
- R11: A dropped data write does not change the line or pixel field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hst_we | input | 1 | Host register write strobe |
| hst_sel | input | 3 | Host register select |
| hst_wdata | input | REG_W | Host write data |
| hst_rdata | output | REG_W | Register read data (combinational on hst_sel) |
| slot_open | input | 1 | Access window from the scan engine |
| sram_we | output | 1 | Frame-buffer write enable |
| sram_addr | output | LINE_W+PIX_W | Frame-buffer address {line, pixel} |
| sram_wdata | output | DATA_W | Frame-buffer write data |

## Verification
The hardest case to reach is a second data write that lands while the first one is still waiting. In normal running the scan engine's window comes often enough to hide this case. The directed tests hold `slot_open` low for long stretches, so the second write meets a busy port. The bench then checks three things: the commit carries the first pixel, the address fields advanced only once, and overrun stays set until the host writes a one to it. The field wraps are reached by loading the address registers right next to the last line and the last pixel, in both modes.

// File: rtl/fbwr_pkg.sv
package fbwr_pkg;

   typedef enum logic [2:0] {
      SEL_CTRL = 3'd0,
      SEL_STAT = 3'd1,
      SEL_LINE = 3'd2,
      SEL_PIX  = 3'd3,
      SEL_DATA = 3'd4
   } fbwr_sel_e;

   localparam int CTRL_ROT_BIT = 0;
   localparam int STAT_BSY_BIT = 0;
   localparam int STAT_OVR_BIT = 1;

endpackage

// File: rtl/fbwr_addr_gen.sv
module fbwr_addr_gen #(
   parameter int LINE_W = 8,
   parameter int PIX_W  = 9,
   parameter int LINES  = 240,
   parameter int PIXELS = 320,
   parameter bit ROT_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_line,
   input  logic              ld_pix,
   input  logic [LINE_W-1:0] ld_line_val,
   input  logic [PIX_W-1:0]  ld_pix_val,
   input  logic              step,
   input  logic              rotate,
   output logic [LINE_W-1:0] line_q,
   output logic [PIX_W-1:0]  pix_q
);

   localparam logic [LINE_W-1:0] LINE_LAST = LINE_W'(LINES - 1);
   localparam logic [PIX_W-1:0]  PIX_LAST  = PIX_W'(PIXELS - 1);

   logic              rot_eff;
   logic              line_end, pix_end;
   logic [LINE_W-1:0] line_inc;
   logic [PIX_W-1:0]  pix_inc;
   logic [LINE_W-1:0] line_nx;
   logic [PIX_W-1:0]  pix_nx;

   generate
      if (ROT_EN) begin : g_rot
         assign rot_eff = rotate;
      end else begin : g_norot
         assign rot_eff = rotate & 1'b0;
      end
   endgenerate

   assign line_end = (line_q == LINE_LAST);
   assign pix_end  = (pix_q == PIX_LAST);
   assign line_inc = line_end ? '0 : line_q + 1'b1;
   assign pix_inc  = pix_end ? '0 : pix_q + 1'b1;

   always_comb begin
      if (rot_eff) begin
         line_nx = line_inc;
         pix_nx  = line_end ? pix_inc : pix_q;
      end else begin
         pix_nx  = pix_inc;
         line_nx = pix_end ? line_inc : line_q;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         line_q <= '0;
         pix_q  <= '0;
      end else begin
         if (ld_line)   line_q <= ld_line_val;
         else if (step) line_q <= line_nx;
         if (ld_pix)    pix_q  <= ld_pix_val;
         else if (step) pix_q  <= pix_nx;
      end
   end

endmodule

// File: rtl/fbwr_pend.sv
module fbwr_pend #(
   parameter int ADDR_W = 17,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [ADDR_W-1:0] push_addr,
   input  logic [DATA_W-1:0] push_data,
   input  logic              slot_open,
   output logic              busy,
   output logic              sram_we,
   output logic [ADDR_W-1:0] sram_addr,
   output logic [DATA_W-1:0] sram_wdata
);

   logic              held_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] data_q;
   logic              commit;

   assign commit = held_q & slot_open;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         held_q <= 1'b0;
         addr_q <= '0;
         data_q <= '0;
      end else if (push) begin
         held_q <= 1'b1;
         addr_q <= push_addr;
         data_q <= push_data;
      end else if (commit) begin
         held_q <= 1'b0;
      end
   end

   assign busy       = held_q;
   assign sram_we    = commit;
   assign sram_addr  = addr_q;
   assign sram_wdata = data_q;

endmodule

// File: rtl/fbwr_regs.sv
module fbwr_regs
   import fbwr_pkg::*;
#(
   parameter int REG_W  = 16,
   parameter int LINE_W = 8,
   parameter int PIX_W  = 9,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hst_we,
   input  logic [2:0]        hst_sel,
   input  logic [REG_W-1:0]  hst_wdata,
   input  logic              busy,
   input  logic [LINE_W-1:0] line_q,
   input  logic [PIX_W-1:0]  pix_q,
   output logic              rotate,
   output logic              ld_line,
   output logic              ld_pix,
   output logic              push,
   output logic [REG_W-1:0]  hst_rdata
);

   logic rot_q, ovr_q;
   logic wr_ctrl, wr_stat, wr_data, reject;
   logic unused_wdata;

   assign wr_ctrl = hst_we && (hst_sel == SEL_CTRL);
   assign wr_stat = hst_we && (hst_sel == SEL_STAT);
   assign ld_line = hst_we && (hst_sel == SEL_LINE);
   assign ld_pix  = hst_we && (hst_sel == SEL_PIX);
   assign wr_data = hst_we && (hst_sel == SEL_DATA);
   assign push    = wr_data && !busy;
   assign reject  = wr_data && busy;

   assign unused_wdata = ^hst_wdata;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rot_q <= 1'b0;
         ovr_q <= 1'b0;
      end else begin
         if (wr_ctrl) rot_q <= hst_wdata[CTRL_ROT_BIT];
         if (reject)
            ovr_q <= 1'b1;
         else if (wr_stat && hst_wdata[STAT_OVR_BIT])
            ovr_q <= 1'b0;
      end
   end

   assign rotate = rot_q;

   always_comb begin
      hst_rdata = '0;
      case (hst_sel)
         SEL_CTRL: hst_rdata[CTRL_ROT_BIT] = rot_q;
         SEL_STAT: begin
            hst_rdata[STAT_BSY_BIT] = busy;
            hst_rdata[STAT_OVR_BIT] = ovr_q;
         end
         SEL_LINE: hst_rdata = REG_W'(line_q);
         SEL_PIX:  hst_rdata = REG_W'(pix_q);
         default:  hst_rdata = '0;
      endcase
   end

endmodule

// File: rtl/fbwr_port.sv
module fbwr_port
   import fbwr_pkg::*;
#(
   parameter int LINE_W = 8,
   parameter int PIX_W  = 9,
   parameter int DATA_W = 8,
   parameter int REG_W  = 16,
   parameter int LINES  = 240,
   parameter int PIXELS = 320,
   parameter bit ROT_EN = 1'b1,
   localparam int ADDR_W = LINE_W + PIX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hst_we,
   input  logic [2:0]        hst_sel,
   input  logic [REG_W-1:0]  hst_wdata,
   output logic [REG_W-1:0]  hst_rdata,
   input  logic              slot_open,
   output logic              sram_we,
   output logic [ADDR_W-1:0] sram_addr,
   output logic [DATA_W-1:0] sram_wdata
);

   generate
      if (LINES < 2 || LINES > (1 << LINE_W)) begin : g_bad_lines
         $error("fbwr_port: LINES does not fit LINE_W");
      end
      if (PIXELS < 2 || PIXELS > (1 << PIX_W)) begin : g_bad_pix
         $error("fbwr_port: PIXELS does not fit PIX_W");
      end
      if (REG_W < LINE_W || REG_W < PIX_W || REG_W < DATA_W || REG_W < 2) begin : g_bad_reg
         $error("fbwr_port: REG_W narrower than a field");
      end
   endgenerate

   logic              busy;
   logic              rotate, ld_line, ld_pix, push;
   logic [LINE_W-1:0] line_q;
   logic [PIX_W-1:0]  pix_q;

   fbwr_regs #(
      .REG_W(REG_W), .LINE_W(LINE_W), .PIX_W(PIX_W), .DATA_W(DATA_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .hst_we(hst_we), .hst_sel(hst_sel), .hst_wdata(hst_wdata),
      .busy(busy), .line_q(line_q), .pix_q(pix_q),
      .rotate(rotate), .ld_line(ld_line), .ld_pix(ld_pix),
      .push(push), .hst_rdata(hst_rdata)
   );

   fbwr_addr_gen #(
      .LINE_W(LINE_W), .PIX_W(PIX_W), .LINES(LINES), .PIXELS(PIXELS), .ROT_EN(ROT_EN)
   ) u_agen (
      .clk(clk), .rst_n(rst_n),
      .ld_line(ld_line), .ld_pix(ld_pix),
      .ld_line_val(hst_wdata[LINE_W-1:0]), .ld_pix_val(hst_wdata[PIX_W-1:0]),
      .step(push), .rotate(rotate),
      .line_q(line_q), .pix_q(pix_q)
   );

   fbwr_pend #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W)
   ) u_pend (
      .clk(clk), .rst_n(rst_n),
      .push(push), .push_addr({line_q, pix_q}), .push_data(hst_wdata[DATA_W-1:0]),
      .slot_open(slot_open), .busy(busy),
      .sram_we(sram_we), .sram_addr(sram_addr), .sram_wdata(sram_wdata)
   );

endmodule

// File: rtl/fbwr_port_chk.sv
module fbwr_port_chk
   import fbwr_pkg::*;
#(
   parameter int ADDR_W = 17,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              hst_we,
   input logic [2:0]        hst_sel,
   input logic              slot_open,
   input logic              busy,
   input logic              sram_we,
   input logic [ADDR_W-1:0] sram_addr,
   input logic [DATA_W-1:0] sram_wdata
);

   a_r3_we_in_slot: assert property (@(posedge clk) disable iff (!rst_n)
      sram_we |-> slot_open);

   a_r10_no_we_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !sram_we);

   a_r2_busy_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (hst_we && hst_sel == SEL_DATA && !busy) |=> busy);

   a_r4_busy_clears: assert property (@(posedge clk) disable iff (!rst_n)
      sram_we |=> !busy);

   a_r5_pending_held: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !sram_we) |=> ($stable(sram_addr) && $stable(sram_wdata)));

endmodule

bind fbwr_port fbwr_port_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .hst_we(hst_we), .hst_sel(hst_sel),
   .slot_open(slot_open), .busy(busy), .sram_we(sram_we),
   .sram_addr(sram_addr), .sram_wdata(sram_wdata)
);

// File: tb/fbwr_port_test.sv
module fbwr_port_test;

   localparam int LINE_W = 8;
   localparam int PIX_W  = 9;
   localparam int DATA_W = 8;
   localparam int REG_W  = 16;
   localparam int ADDR_W = LINE_W + PIX_W;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              hst_we = 1'b0;
   logic [2:0]        hst_sel = 3'd0;
   logic [REG_W-1:0]  hst_wdata = '0;
   logic [REG_W-1:0]  hst_rdata;
   logic              slot_open = 1'b0;
   logic              sram_we;
   logic [ADDR_W-1:0] sram_addr;
   logic [DATA_W-1:0] sram_wdata;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   fbwr_port uut (
      .clk(clk), .rst_n(rst_n), .hst_we(hst_we), .hst_sel(hst_sel),
      .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .slot_open(slot_open),
      .sram_we(sram_we), .sram_addr(sram_addr), .sram_wdata(sram_wdata)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] sel, input logic [REG_W-1:0] val);
      @(negedge clk);
      hst_we = 1'b1; hst_sel = sel; hst_wdata = val;
      @(negedge clk);
      hst_we = 1'b0; hst_wdata = '0;
   endtask

   task automatic rd(input logic [2:0] sel, output logic [REG_W-1:0] val);
      hst_sel = sel;
      #1;
      val = hst_rdata;
   endtask

   task automatic commit(input int eline, input int epix, input int edata, input string tag);
      logic [REG_W-1:0] v;
      @(negedge clk);
      slot_open = 1'b1;
      #1;
      check({tag, " R3 we"}, 32'(sram_we), 32'd1);
      check({tag, " R3 addr"}, 32'(sram_addr), 32'((eline << PIX_W) | epix));
      check({tag, " R3 data"}, 32'(sram_wdata), 32'(edata));
      @(negedge clk);
      slot_open = 1'b0;
      rd(3'd1, v);
      check({tag, " R4 busy clear"}, 32'(v[0]), 32'd0);
   endtask

   task automatic chk_addr(input int eline, input int epix, input string tag);
      logic [REG_W-1:0] v;
      rd(3'd2, v); check({tag, " line"}, 32'(v), 32'(eline));
      rd(3'd3, v); check({tag, " pix"}, 32'(v), 32'(epix));
   endtask

   task automatic t_reset;
      logic [REG_W-1:0] v;
      rd(3'd0, v); check("R1 ctrl", 32'(v), 0);
      rd(3'd1, v); check("R1 stat", 32'(v), 0);
      chk_addr(0, 0, "R1");
      check("R1 sram_we", 32'(sram_we), 0);
   endtask

   task automatic t_basic;
      logic [REG_W-1:0] v;
      wr(3'd4, 16'h005A);
      rd(3'd1, v); check("R2 busy set", 32'(v[0]), 1);
      check("R2 no write before slot", 32'(sram_we), 0);
      chk_addr(0, 1, "R7 step");
      commit(0, 0, 8'h5A, "basic");
   endtask

   task automatic t_idle_slot;
      @(negedge clk);
      slot_open = 1'b1;
      #1;
      check("R10 idle slot", 32'(sram_we), 0);
      @(negedge clk);
      slot_open = 1'b0;
   endtask

   task automatic t_overrun;
      logic [REG_W-1:0] v;
      wr(3'd2, 16'd20); wr(3'd3, 16'd30);
      chk_addr(20, 30, "R9 load");
      wr(3'd4, 16'h00A1);
      wr(3'd4, 16'h00B2);
      rd(3'd1, v); check("R5 busy+overrun", 32'(v), 3);
      chk_addr(20, 31, "R11 no double step");
      commit(20, 30, 8'hA1, "R5 first kept");
      wr(3'd1, 16'h0000);
      rd(3'd1, v); check("R6 write0 keeps", 32'(v), 2);
      wr(3'd1, 16'h0002);
      rd(3'd1, v); check("R6 write1 clears", 32'(v), 0);
   endtask

   task automatic t_wrap_normal;
      wr(3'd2, 16'd5); wr(3'd3, 16'd319);
      wr(3'd4, 16'h0011);
      chk_addr(6, 0, "R7 pix wrap");
      commit(5, 319, 8'h11, "R7 wrap");
      wr(3'd2, 16'd239); wr(3'd3, 16'd319);
      wr(3'd4, 16'h0022);
      chk_addr(0, 0, "R7 full wrap");
      commit(239, 319, 8'h22, "R7 full");
   endtask

   task automatic t_rotate;
      logic [REG_W-1:0] v;
      wr(3'd0, 16'h0001);
      rd(3'd0, v); check("R8 rotate bit", 32'(v), 1);
      wr(3'd2, 16'd10); wr(3'd3, 16'd7);
      wr(3'd4, 16'h0033);
      chk_addr(11, 7, "R8 line step");
      commit(10, 7, 8'h33, "R8 a");
      wr(3'd2, 16'd239);
      wr(3'd4, 16'h0044);
      chk_addr(0, 8, "R8 line wrap");
      commit(239, 7, 8'h44, "R8 b");
      wr(3'd2, 16'd239); wr(3'd3, 16'd319);
      wr(3'd4, 16'h0055);
      chk_addr(0, 0, "R8 full wrap");
      commit(239, 319, 8'h55, "R8 c");
      wr(3'd0, 16'h0000);
   endtask

   initial begin
      #(4 * 100000);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      t_reset;
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_basic;
      t_idle_slot;
      t_overrun;
      t_wrap_normal;
      t_rotate;
      repeat (2) @(negedge clk);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule